// File: doc/BRIEF.md
# SerDes Lane Override Sequencer

This block forces one SerDes receive/transmit lane into fixed settings after a link reset. It does not touch the lane registers itself. It sends a series of single read or write requests to an indirect register accessor, and each write is built from a value it read back from the lane. A start pulse selects a lane (0 to 3), a receive DPLL mode and a 4-bit transmit attenuation value, all captured on the start cycle. The block first waits, within a bound, for the lane's half-rate status to clear. It then sets up the receive override, including a DPLL reset pulse, and waits a settle time given by a parameter. Last, it sets up the transmit override unless the attenuation value asks to leave transmit alone.

A separate release command does one read-modify-write that turns the receive override off. `busy` is high while either sequence runs. `done` marks the end of a sequence with a single-cycle pulse.

Top module: `lane_force_seq`

## Requirements
- R1: After reset, `busy`, `done` and `acc_req` are low, and no request is made while the block is idle.
- R2: Every access goes to base + lane*0x100. The bases are 0x2001 for transmit status, 0x2002 for receive status, 0x2004 for the transmit override and 0x2005 for the receive override.
- R3: After polling, a start reads receive status. It then writes five values to the receive override, in this order: the read value with bit 14 cleared; the same value with bit 14 set; that value with bits 10:8 replaced by the DPLL mode; that value with bit 11 set; that value with bit 11 cleared.
- R4: A start first reads receive status and repeats the read while bit 0 is 1. It stops after at most POLL_LIMIT such reads and then continues whether or not bit 0 has cleared.
- R5: When attenuation bit 3 is 0, the block reads transmit status after the settle wait. It then writes three values to the transmit override: the read value with bit 15 cleared; that value with bit 15 set; that value ORed with attenuation bits 2:0 placed at bits 12:10.
- R6: When attenuation bit 3 is 1, the sequence ends after the settle wait with no transmit read or write.
- R7: A release pulse while idle reads receive status and writes it, with bit 14 cleared, to the receive override. It makes no other access.
- R8: `done` is high for exactly one cycle when a sequence ends, and `busy` is low in that cycle.
- R9: At least SETTLE_CYCLES clock cycles pass between the acknowledge of the last receive override write and the next request.
- R10: A start or release pulse that arrives while `busy` is high is ignored. It changes neither the running sequence nor the number of `done` pulses.
- R11: Only one request is outstanding at a time. `acc_req` and its address, direction and data stay unchanged until `acc_ack`, and the request drops on the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start the override sequence (pulse) |
| release_req | input | 1 | Start the receive-override release (pulse) |
| lane | input | LW | Lane number |
| dpll_mode | input | 3 | Receive DPLL mode for bits 10:8 |
| tx_atten | input | 4 | Transmit attenuation; bit 3 set skips transmit |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| acc_req | output | 1 | Accessor request valid |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_addr | output | AW | Accessor register address |
| acc_wdata | output | DW | Accessor write data |
| acc_ack | input | 1 | Accessor acknowledge; read data valid with it |
| acc_rdata | input | DW | Accessor read data |

## Verification
The request is registered on the edge after the sequencer issues it, so it appears one cycle after the step begins. The read data or the write completion is taken up on the cycle after `acc_ack`, and the next request follows two edges later. `done` rises on the edge after the final access completes. The bench's accessor model logs every access in the order it is acknowledged and compares the log with the expected list only after `done` has been seen at a falling-edge sample. The settle wait is measured with edge counters in the model. The gap from the last receive write's acknowledge to the next request is checked to be at least SETTLE_CYCLES and no more than a few pipeline cycles beyond it.

// File: rtl/lane_force_pkg.sv
package lane_force_pkg;

  // Register bases inside a lane window
  localparam logic [15:0] ADR_TX_STS = 16'h2001;
  localparam logic [15:0] ADR_RX_STS = 16'h2002;
  localparam logic [15:0] ADR_TX_OVR = 16'h2004;
  localparam logic [15:0] ADR_RX_OVR = 16'h2005;

  // Field positions the lane decodes
  localparam int BIT_HALF    = 0;
  localparam int BIT_RX_EN   = 14;
  localparam int BIT_TX_EN   = 15;
  localparam int BIT_PLL_RST = 11;
  localparam int PLL_LSB     = 8;
  localparam int ATT_LSB     = 10;
  localparam int ATT_SKIP    = 3;
  localparam int MODE_W      = 3;
  localparam int ATT_W       = 4;

  typedef enum logic [1:0] {REG_TXS, REG_RXS, REG_TXO, REG_RXO} reg_sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_RX_RD, S_RX_CLR, S_RX_SET, S_RX_MODE, S_RX_RST1,
    S_RX_RST0, S_SETTLE, S_TX_RD, S_TX_CLR, S_TX_SET, S_TX_ATT,
    S_DIS_RD, S_DIS_WR
  } seq_st_e;

  function automatic logic st_is_op(seq_st_e s);
    return !(s == S_IDLE || s == S_SETTLE);
  endfunction

  function automatic logic st_is_wr(seq_st_e s);
    return s inside {S_RX_CLR, S_RX_SET, S_RX_MODE, S_RX_RST1, S_RX_RST0,
                     S_TX_CLR, S_TX_SET, S_TX_ATT, S_DIS_WR};
  endfunction

  function automatic reg_sel_e st_reg(seq_st_e s);
    case (s)
      S_POLL, S_RX_RD, S_DIS_RD:    return REG_RXS;
      S_TX_RD:                      return REG_TXS;
      S_TX_CLR, S_TX_SET, S_TX_ATT: return REG_TXO;
      default:                      return REG_RXO;
    endcase
  endfunction

endpackage

// File: rtl/lane_force_xfer.sv
module lane_force_xfer #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          op_done,
  output logic [DW-1:0] op_rdata,
  output logic          acc_req,
  output logic          acc_we,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  input  logic          acc_ack,
  input  logic [DW-1:0] acc_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_req   <= 1'b0;
      acc_we    <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      op_done   <= 1'b0;
      op_rdata  <= '0;
    end else begin
      op_done <= 1'b0;
      if (acc_req && acc_ack) begin
        acc_req  <= 1'b0;
        op_done  <= 1'b1;
        op_rdata <= acc_rdata;
      end else if (go && !acc_req) begin
        acc_req   <= 1'b1;
        acc_we    <= we;
        acc_addr  <= addr;
        acc_wdata <= wdata;
      end
    end
  end

endmodule

// File: rtl/lane_force_timer.sv
module lane_force_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lane_force_ctrl.sv
module lane_force_ctrl
  import lane_force_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 16,
  parameter int LW            = 2,
  parameter int LANE_STRIDE   = 256,
  parameter int POLL_LIMIT    = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              release_req,
  input  logic [LW-1:0]     lane,
  input  logic [MODE_W-1:0] dpll_mode,
  input  logic [ATT_W-1:0]  tx_atten,
  input  logic              op_done,
  input  logic [DW-1:0]     op_rdata,
  input  logic              tmr_expired,
  output logic              go,
  output logic              we,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     wdata,
  output logic              tmr_load,
  output logic              busy,
  output logic              done
);

  localparam int PW = $clog2(POLL_LIMIT + 1);

  seq_st_e           st_q, st_nx;
  logic              wait_q;
  logic [LW-1:0]     lane_q;
  logic [MODE_W-1:0] mode_q;
  logic [ATT_W-1:0]  att_q;
  logic [DW-1:0]     shadow_q;
  logic [PW-1:0]     poll_q;
  logic [AW-1:0]     base;

  assign go       = st_is_op(st_q) && !wait_q;
  assign we       = st_is_wr(st_q);
  assign wdata    = shadow_q;
  assign tmr_load = (st_q == S_RX_RST0) && op_done;

  always_comb begin
    case (st_reg(st_q))
      REG_TXS: base = AW'(ADR_TX_STS);
      REG_RXS: base = AW'(ADR_RX_STS);
      REG_TXO: base = AW'(ADR_TX_OVR);
      default: base = AW'(ADR_RX_OVR);
    endcase
    addr = base + AW'(lane_q) * AW'(LANE_STRIDE);
  end

  always_comb begin
    st_nx = st_q;
    case (st_q)
      S_IDLE: begin
        if (start)            st_nx = S_POLL;
        else if (release_req) st_nx = S_DIS_RD;
      end
      S_POLL: begin
        if (op_done) begin
          if (op_rdata[BIT_HALF] && (int'(poll_q) + 1 < POLL_LIMIT))
            st_nx = S_POLL;
          else
            st_nx = S_RX_RD;
        end
      end
      S_RX_RD:   if (op_done) st_nx = S_RX_CLR;
      S_RX_CLR:  if (op_done) st_nx = S_RX_SET;
      S_RX_SET:  if (op_done) st_nx = S_RX_MODE;
      S_RX_MODE: if (op_done) st_nx = S_RX_RST1;
      S_RX_RST1: if (op_done) st_nx = S_RX_RST0;
      S_RX_RST0: if (op_done) st_nx = S_SETTLE;
      S_SETTLE: begin
        if (tmr_expired) st_nx = att_q[ATT_SKIP] ? S_IDLE : S_TX_RD;
      end
      S_TX_RD:   if (op_done) st_nx = S_TX_CLR;
      S_TX_CLR:  if (op_done) st_nx = S_TX_SET;
      S_TX_SET:  if (op_done) st_nx = S_TX_ATT;
      S_TX_ATT:  if (op_done) st_nx = S_IDLE;
      S_DIS_RD:  if (op_done) st_nx = S_DIS_WR;
      S_DIS_WR:  if (op_done) st_nx = S_IDLE;
      default:   st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      wait_q   <= 1'b0;
      lane_q   <= '0;
      mode_q   <= '0;
      att_q    <= '0;
      shadow_q <= '0;
      poll_q   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      st_q <= st_nx;
      busy <= (st_nx != S_IDLE);
      done <= (st_q != S_IDLE) && (st_nx == S_IDLE);

      if (op_done)  wait_q <= 1'b0;
      else if (go)  wait_q <= 1'b1;

      if (st_q == S_IDLE && st_nx != S_IDLE) begin
        lane_q <= lane;
        mode_q <= dpll_mode;
        att_q  <= tx_atten;
        poll_q <= '0;
      end

      if (op_done) begin
        case (st_q)
          S_POLL: poll_q <= poll_q + 1'b1;
          S_RX_RD, S_DIS_RD: begin
            shadow_q            <= op_rdata;
            shadow_q[BIT_RX_EN] <= 1'b0;
          end
          S_RX_CLR:  shadow_q[BIT_RX_EN] <= 1'b1;
          S_RX_SET:  shadow_q[PLL_LSB +: MODE_W] <= mode_q;
          S_RX_MODE: shadow_q[BIT_PLL_RST] <= 1'b1;
          S_RX_RST1: shadow_q[BIT_PLL_RST] <= 1'b0;
          S_TX_RD: begin
            shadow_q            <= op_rdata;
            shadow_q[BIT_TX_EN] <= 1'b0;
          end
          S_TX_CLR:  shadow_q[BIT_TX_EN] <= 1'b1;
          S_TX_SET:  shadow_q[ATT_LSB +: 3] <= shadow_q[ATT_LSB +: 3] | att_q[2:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/lane_force_seq.sv
module lane_force_seq
  import lane_force_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 16,
  parameter int LANES         = 4,
  parameter int LANE_STRIDE   = 256,
  parameter int POLL_LIMIT    = 1000,
  parameter int SETTLE_CYCLES = 3_000_000,
  localparam int LW           = $clog2(LANES),
  localparam int CW           = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              release_req,
  input  logic [LW-1:0]     lane,
  input  logic [MODE_W-1:0] dpll_mode,
  input  logic [ATT_W-1:0]  tx_atten,
  output logic              busy,
  output logic              done,
  output logic              acc_req,
  output logic              acc_we,
  output logic [AW-1:0]     acc_addr,
  output logic [DW-1:0]     acc_wdata,
  input  logic              acc_ack,
  input  logic [DW-1:0]     acc_rdata
);

  logic          go, we, op_done, tmr_load, tmr_expired;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, op_rdata;

  lane_force_ctrl #(
    .AW(AW), .DW(DW), .LW(LW), .LANE_STRIDE(LANE_STRIDE), .POLL_LIMIT(POLL_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .release_req(release_req),
    .lane(lane), .dpll_mode(dpll_mode), .tx_atten(tx_atten),
    .op_done(op_done), .op_rdata(op_rdata), .tmr_expired(tmr_expired),
    .go(go), .we(we), .addr(addr), .wdata(wdata), .tmr_load(tmr_load),
    .busy(busy), .done(done)
  );

  lane_force_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk(clk), .rst(rst), .go(go), .we(we), .addr(addr), .wdata(wdata),
    .op_done(op_done), .op_rdata(op_rdata),
    .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata)
  );

  lane_force_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(CW'(SETTLE_CYCLES)),
    .expired(tmr_expired)
  );

endmodule

// File: rtl/lane_force_seq_chk.sv
module lane_force_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          release_req,
  input logic          busy,
  input logic          done,
  input logic          acc_req,
  input logic          acc_we,
  input logic [AW-1:0] acc_addr,
  input logic [DW-1:0] acc_wdata,
  input logic          acc_ack
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !acc_req);

  p_hold_req_r11: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_ack) |=> (acc_req && $stable(acc_addr) && $stable(acc_we)
                               && $stable(acc_wdata)));

  p_ack_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_ack) |=> !acc_req);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_start_take_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_release_take_r7: assert property (@(posedge clk) disable iff (rst)
    (release_req && !busy) |=> busy);

endmodule

bind lane_force_seq lane_force_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .release_req(release_req),
  .busy(busy), .done(done), .acc_req(acc_req), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack)
);

// File: tb/lane_force_seq_bench.sv
`timescale 1ns/1ps
module lane_force_seq_bench;

  localparam int SETTLE = 40;
  localparam int PLIM   = 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, release_req = 1'b0;
  logic [1:0]  lane = '0;
  logic [2:0]  dpll_mode = '0;
  logic [3:0]  tx_atten = '0;
  logic        busy, done, acc_req, acc_we, acc_ack;
  logic [15:0] acc_addr, acc_wdata, acc_rdata;

  always #2.5 clk = ~clk;

  lane_force_seq #(.SETTLE_CYCLES(SETTLE), .POLL_LIMIT(PLIM)) u_lane_force_seq (
    .clk(clk), .rst(rst), .start(start), .release_req(release_req),
    .lane(lane), .dpll_mode(dpll_mode), .tx_atten(tx_atten),
    .busy(busy), .done(done), .acc_req(acc_req), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
    .acc_rdata(acc_rdata)
  );

  int total = 0, bad = 0;

  // accessor model state
  logic [15:0] rx_sts [4];
  logic [15:0] tx_sts [4];
  int hr_left = 0, ack_dly = 1, ack_cnt = 0, cyc = 0;
  int wn = 0, rx_rd_n = 0, tx_rd_n = 0, done_n = 0;
  logic [15:0] wa [32];
  logic [15:0] wd [32];
  int wack_cyc [32];
  int req_start = 0, txrd_start = 0;
  logic req_prev = 1'b0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done) done_n = done_n + 1;
    if (acc_req && !req_prev) req_start = cyc;
    req_prev = acc_req;
    if (rst) begin
      acc_ack   <= 1'b0;
      acc_rdata <= '0;
      ack_cnt = 0;
    end else if (acc_req && !acc_ack) begin
      if (ack_cnt + 1 >= ack_dly) begin
        acc_ack <= 1'b1;
        ack_cnt = 0;
        if (acc_we) begin
          if (wn < 32) begin
            wa[wn] = acc_addr; wd[wn] = acc_wdata; wack_cyc[wn] = cyc;
          end
          wn = wn + 1;
        end else if (acc_addr[7:0] == 8'h02) begin
          acc_rdata <= rx_sts[acc_addr[9:8]] | {15'd0, (hr_left > 0)};
          if (hr_left > 0) hr_left = hr_left - 1;
          rx_rd_n = rx_rd_n + 1;
        end else begin
          acc_rdata <= tx_sts[acc_addr[9:8]];
          tx_rd_n = tx_rd_n + 1;
          txrd_start = req_start;
        end
      end else ack_cnt = ack_cnt + 1;
    end else begin
      acc_ack <= 1'b0;
      ack_cnt = 0;
    end
  end

  // expected write list
  logic [15:0] ea [32];
  logic [15:0] ed [32];
  int en = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic [15:0] d);
    ea[en] = a; ed[en] = d; en++;
  endtask

  task automatic build_start(input int l, input logic [2:0] m, input logic [3:0] at,
                             input logic [15:0] rxv, input logic [15:0] txv);
    logic [15:0] t, ro, to;
    en = 0;
    ro = 16'h2005 + 16'(l) * 16'h0100;
    to = 16'h2004 + 16'(l) * 16'h0100;
    t = rxv & ~16'h4000;                   push(ro, t);
    t = t | 16'h4000;                      push(ro, t);
    t = (t & ~16'h0700) | {5'd0, m, 8'd0}; push(ro, t);
    t = t | 16'h0800;                      push(ro, t);
    t = t & ~16'h0800;                     push(ro, t);
    if (!at[3]) begin
      t = txv & ~16'h8000;                 push(to, t);
      t = t | 16'h8000;                    push(to, t);
      t = t | {3'd0, at[2:0], 10'd0};      push(to, t);
    end
  endtask

  task automatic cmp_writes(input string req);
    chk(wn == en, {req, " write count"}, wn, en);
    for (int i = 0; i < en && i < wn; i++) begin
      chk(wa[i] == ea[i], {req, " write addr"}, wa[i], ea[i]);
      chk(wd[i] == ed[i], {req, " write data"}, wd[i], ed[i]);
    end
  endtask

  task automatic clear_log();
    wn = 0; rx_rd_n = 0; tx_rd_n = 0; done_n = 0;
  endtask

  task automatic pulse_start(input int l, input logic [2:0] m, input logic [3:0] at);
    @(negedge clk);
    start = 1'b1; lane = 2'(l); dpll_mode = m; tx_atten = at;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done_n == 0 && n < 20000) begin @(negedge clk); n++; end
    chk(done_n != 0, {req, " done seen"}, done_n, 1);
    repeat (3) @(negedge clk);
    chk(done_n == 1, "R8 single done pulse", done_n, 1);
    chk(!busy, "R8 busy low after done", busy, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!done, "R1 done after reset", done, 0);
    chk(!acc_req, "R1 acc_req after reset", acc_req, 0);
    repeat (10) @(negedge clk);
    chk(wn == 0 && rx_rd_n == 0 && tx_rd_n == 0, "R1 no access while idle",
        wn + rx_rd_n + tx_rd_n, 0);
  endtask

  task automatic t_basic();
    clear_log(); ack_dly = 1;
    rx_sts[1] = 16'h4B34; tx_sts[1] = 16'h8122;
    build_start(1, 3'd3, 4'd5, 16'h4B34, 16'h8122);
    pulse_start(1, 3'd3, 4'd5);
    chk(busy, "R10 busy while running", busy, 1);
    wait_done("R3");
    cmp_writes("R2 R3 R5 basic");
    chk(rx_rd_n == 2, "R4 one clear poll plus one read", rx_rd_n, 2);
    chk(txrd_start - wack_cyc[4] >= SETTLE, "R9 settle gap minimum",
        txrd_start - wack_cyc[4], SETTLE);
    chk(txrd_start - wack_cyc[4] <= SETTLE + 8, "R9 settle gap maximum",
        txrd_start - wack_cyc[4], SETTLE + 8);
  endtask

  task automatic t_mode_slow_ack();
    clear_log(); ack_dly = 3;
    rx_sts[0] = 16'h0710; tx_sts[0] = 16'h0400;
    build_start(0, 3'd2, 4'd2, 16'h0710, 16'h0400);
    pulse_start(0, 3'd2, 4'd2);
    wait_done("R11");
    cmp_writes("R3 R5 R11 mode replace, atten OR, slow ack");
    ack_dly = 1;
  endtask

  task automatic t_skip_tx();
    clear_log();
    rx_sts[2] = 16'h0001 ^ 16'h0001; tx_sts[2] = 16'hFFFF;
    build_start(2, 3'd5, 4'hB, 16'h0000, 16'hFFFF);
    pulse_start(2, 3'd5, 4'hB);
    wait_done("R6");
    cmp_writes("R6 skip transmit");
    chk(tx_rd_n == 0, "R6 no transmit read", tx_rd_n, 0);
  endtask

  task automatic t_release();
    clear_log();
    rx_sts[3] = 16'h7FFE;
    en = 0; push(16'h2305, 16'h3FFE);
    @(negedge clk); release_req = 1'b1; lane = 2'd3;
    @(negedge clk); release_req = 1'b0;
    wait_done("R7");
    cmp_writes("R7 release");
    chk(rx_rd_n == 1 && tx_rd_n == 0, "R7 single status read", rx_rd_n, 1);
  endtask

  task automatic t_poll_short();
    clear_log();
    rx_sts[0] = 16'h1234; tx_sts[0] = 16'h0000; hr_left = 3;
    build_start(0, 3'd1, 4'd0, 16'h1234, 16'h0000);
    pulse_start(0, 3'd1, 4'd0);
    wait_done("R4");
    chk(rx_rd_n == 5, "R4 polls until half-rate clears", rx_rd_n, 5);
    cmp_writes("R4 after short poll");
  endtask

  task automatic t_poll_limit();
    clear_log();
    rx_sts[1] = 16'h0000; tx_sts[1] = 16'h0000; hr_left = 100000;
    build_start(1, 3'd3, 4'h8, 16'h0001, 16'h0000);
    pulse_start(1, 3'd3, 4'h8);
    wait_done("R4");
    chk(rx_rd_n == PLIM + 1, "R4 poll bound", rx_rd_n, PLIM + 1);
    cmp_writes("R4 continues after bound");
    hr_left = 0;
  endtask

  task automatic t_busy_ignore();
    int w;
    clear_log();
    rx_sts[0] = 16'h0000; tx_sts[0] = 16'h0000;
    build_start(0, 3'd3, 4'd4, 16'h0000, 16'h0000);
    pulse_start(0, 3'd3, 4'd4);
    repeat (4) @(negedge clk);
    start = 1'b1; lane = 2'd3; tx_atten = 4'd1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    release_req = 1'b1; lane = 2'd2;
    @(negedge clk); release_req = 1'b0;
    wait_done("R10");
    cmp_writes("R10 start/release while busy ignored");
    w = wn;
    repeat (20) @(negedge clk);
    chk(wn == w && done_n == 1 && !busy, "R10 no extra sequence", wn, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin rx_sts[i] = '0; tx_sts[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_mode_slow_ack();
    t_skip_tx();
    t_release();
    t_poll_short();
    t_poll_limit();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule